// File: doc/BRIEF.md
# General-Purpose Strobe Port Controller

This block drives one general-purpose strobe pin of a host bus-interface controller. Software picks one of four modes through a two-bit field of a control register. In the write-strobe mode the pin pulses low while the host writes the external port register index. The pin can then clock an external 8-bit output latch. An internal shadow register captures the same byte, and host reads of that index return the shadow value. In the read-strobe mode the pin pulses low while the host reads the port index. This lets an external 8-bit input buffer drive the upper byte of the host data bus. The block leaves that byte undriven, samples it during the pulse and keeps it in the shadow register. In the two remaining modes the pin stays inactive and the port index acts as a plain internal register.

The host side is modelled as follows. A data-port select, the current value of the index register, and the active-low I/O read and write pulses arrive as inputs, together with the 16-bit write data. The block returns read data with a separate drive enable for each byte lane. A control bit chooses between a push-pull pin driver and an open-drain style driver that relies on an external pull-up. Writes and read captures take effect on the trailing edge of the host pulse. The pulses are assumed to be already synchronous to the block clock.

Top module: `gps_strobe_port`

## Requirements
- R1: After a synchronous reset, the control register and the shadow register both read 00h, and the pin does not pull low.
- R2: With mode field ctl[4:3] = 2'b10, a selected host write to index 0Ah holds the strobe active (low) in exactly the cycles where host_wr_n is low, and in no other cycles.
- R3: A selected write to index 0Ah loads host_din[15:8] into the shadow register one cycle after host_wr_n rises. Outside mode 2'b01, a selected read of index 0Ah returns the shadow on host_dout[15:8], with host_oe_hi = 1 and host_dout[7:0] = 0.
- R4: With ctl[4:3] = 2'b01, a selected read of index 0Ah holds the strobe active in exactly the cycles where host_rd_n is low, and keeps host_oe_hi at 0.
- R5: With ctl[4:3] = 2'b01, the value on host_din[15:8] during the last low cycle of a selected read of index 0Ah enters the shadow register one cycle after host_rd_n rises.
- R6: With ctl[4:3] = 2'b00 or 2'b11, the strobe never becomes active. Writes and reads of index 0Ah still update the shadow and return it as in R3.
- R7: The control register sits at index 2Fh on host_din/host_dout bits 7:0 (read with host_oe_lo = 1). Accesses to any index other than 0Ah never activate the strobe.
- R8: With ctl[2] = 1 the pin is push-pull: gps_oe = 1 and gps_o is the strobe level. With ctl[2] = 0, gps_o = 0 and gps_oe = 1 only while the strobe is active.
- R9: Pulses with host_sel = 0 change neither register, drive no data and leave the strobe inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access addresses the indexed data port |
| host_index | input | 8 | Current value of the host index register |
| host_wr_n | input | 1 | Host I/O write pulse, active low |
| host_rd_n | input | 1 | Host I/O read pulse, active low |
| host_din | input | 16 | Host data bus as seen by the block |
| host_dout | output | 16 | Read data returned to the host |
| host_oe_hi | output | 1 | Block drives host_dout[15:8] |
| host_oe_lo | output | 1 | Block drives host_dout[7:0] |
| gps_o | output | 1 | Strobe pin output level |
| gps_oe | output | 1 | Strobe pin output enable |

## Verification
The bench builds the block with a 16-bit host bus, an 8-bit port lane, port index 0Ah and control index 2Fh. These values put the port byte in the upper lane and the control byte in the lower lane, so lane-swap and lane-drive errors become visible. Across all four mode values and both driver styles, it exercises pulses of one and several cycles. This covers the exact extent of the strobe, the trailing-edge capture in both directions, unselected accesses, and accesses to a neighbouring index.

// File: rtl/gps_pkg.sv
// Package: shared mode encoding and control-field positions for the
// general-purpose strobe port. Assumes an 8-bit control register.
package gps_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_RDSTB = 2'b01,
        MODE_WRSTB = 2'b10,
        MODE_PLAIN = 2'b11
    } gps_mode_e;

    localparam int CTRL_W       = 8;
    localparam int MODE_LSB     = 3;
    localparam int DRV_BIT      = 2;

endpackage

// File: rtl/gps_access_decode.sv
// Module: gps_access_decode
// Decodes a host data-port access into port and control hits and forms the
// combinational strobe request. Assumes host_index is stable while a pulse
// is low, so the AND of select and pulse cannot glitch.
module gps_access_decode
    import gps_pkg::*;
#(
    parameter int          IDX_W    = 8,
    parameter logic [7:0]  PORT_IDX = 8'h0A,
    parameter logic [7:0]  CTRL_IDX = 8'h2F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_sel,
    input  logic [IDX_W-1:0] host_index,
    input  logic             host_wr_n,
    input  logic             host_rd_n,
    input  gps_mode_e        mode,
    output logic             port_hit,
    output logic             ctrl_hit,
    output logic             strobe_act
);

    localparam logic [IDX_W-1:0] PORT_SEL = IDX_W'(PORT_IDX);
    localparam logic [IDX_W-1:0] CTRL_SEL = IDX_W'(CTRL_IDX);

    // Index match qualified by the data-port select.
    always_comb begin
        port_hit = host_sel && (host_index == PORT_SEL);
        ctrl_hit = host_sel && (host_index == CTRL_SEL);
    end

    // Strobe request: port hit ANDed with the pulse the mode picks.
    always_comb begin
        unique case (mode)
            MODE_WRSTB: strobe_act = port_hit && !host_wr_n;
            MODE_RDSTB: strobe_act = port_hit && !host_rd_n;
            default:    strobe_act = 1'b0;
        endcase
    end

    // R7: an active strobe always belongs to a port-index access.
    p_strobe_port_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_act |-> (host_sel && host_index == PORT_SEL))
        else $error("strobe active outside port index");

    // R2/R4: strobe only while some host pulse is low.
    p_strobe_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_act |-> (!host_wr_n || !host_rd_n))
        else $error("strobe active without host pulse");

endmodule

// File: rtl/gps_regfile.sv
// Module: gps_regfile
// Holds the control register and the port shadow register. Both load on
// the trailing edge of the host pulse, using the select and data seen in
// the last low cycle. Assumes the pulses are synchronous to clk and that
// read and write pulses are never low together.
module gps_regfile
    import gps_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [DATA_W-1:0] host_din,
    input  logic              port_hit,
    input  logic              ctrl_hit,
    output logic [CTRL_W-1:0] ctl,
    output logic [PORT_W-1:0] shadow,
    output gps_mode_e         mode
);

    localparam int PORT_LSB = DATA_W - PORT_W;

    logic              wr_low_q;
    logic              rd_low_q;
    logic              wcap_port;
    logic              wcap_ctrl;
    logic [DATA_W-1:0] wcap_data;
    logic              rcap_port;
    logic [PORT_W-1:0] rcap_data;
    logic              wr_end;
    logic              rd_end;
    logic              past_vld;

    // Trailing edges of the host pulses.
    always_comb begin
        wr_end = wr_low_q && host_wr_n;
        rd_end = rd_low_q && host_rd_n;
    end

    // Mode field as seen by the rest of the block.
    always_comb mode = gps_mode_e'(ctl[MODE_LSB +: 2]);

    // Pulse trackers: remember the select and data of the latest low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_low_q  <= 1'b0;
            rd_low_q  <= 1'b0;
            wcap_port <= 1'b0;
            wcap_ctrl <= 1'b0;
            wcap_data <= '0;
            rcap_port <= 1'b0;
            rcap_data <= '0;
        end else begin
            wr_low_q <= !host_wr_n;
            rd_low_q <= !host_rd_n;
            if (!host_wr_n) begin
                wcap_port <= port_hit;
                wcap_ctrl <= ctrl_hit;
                wcap_data <= host_din;
            end
            if (!host_rd_n) begin
                rcap_port <= port_hit && (mode == MODE_RDSTB);
                rcap_data <= host_din[PORT_LSB +: PORT_W];
            end
        end
    end

    // Register commit on trailing edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl    <= '0;
            shadow <= '0;
        end else begin
            if (wr_end && wcap_ctrl) ctl <= wcap_data[CTRL_W-1:0];
            if (wr_end && wcap_port) begin
                shadow <= wcap_data[PORT_LSB +: PORT_W];
            end else if (rd_end && rcap_port) begin
                shadow <= rcap_data;
            end
        end
    end

    // Marks that at least one cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_vld <= 1'b0;
        else        past_vld <= 1'b1;
    end

    // R3/R5: the shadow only moves right after a pulse ends.
    p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_vld && host_wr_n && host_rd_n && $past(host_wr_n) && $past(host_rd_n))
        |=> $stable(shadow))
        else $error("shadow changed without a finished pulse");

    // R7: the control register never changes during a read pulse.
    p_ctl_hold_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_vld && !host_rd_n && host_wr_n) |=> $stable(ctl))
        else $error("control register changed during read");

endmodule

// File: rtl/gps_pin_drv.sv
// Module: gps_pin_drv
// Maps the strobe request onto the pin. In push-pull style the pin is
// always enabled and follows the inverted request. In open-drain style it
// is enabled only to pull low, and an external pull-up supplies the high.
module gps_pin_drv (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_act,
    input  logic push_pull,
    output logic pin_o,
    output logic pin_oe
);

    // Driver style selection.
    always_comb begin
        if (push_pull) begin
            pin_o  = !strobe_act;
            pin_oe = 1'b1;
        end else begin
            pin_o  = 1'b0;
            pin_oe = strobe_act;
        end
    end

    // R8: open-drain style only ever drives a low.
    p_od_low_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_pull && pin_oe) |-> !pin_o)
        else $error("open-drain pin driving high");

    // R8: push-pull style never floats.
    p_pp_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> pin_oe)
        else $error("push-pull pin floating");

endmodule

// File: rtl/gps_strobe_port.sv
// Module: gps_strobe_port (top)
// General-purpose strobe port: decodes host accesses, keeps the control
// and shadow registers, returns read data per byte lane and drives the
// strobe pin. Assumes DATA_W >= PORT_W + 8 so the lanes do not overlap.
module gps_strobe_port
    import gps_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter int          PORT_W   = 8,
    parameter int          IDX_W    = 8,
    parameter logic [7:0]  PORT_IDX = 8'h0A,
    parameter logic [7:0]  CTRL_IDX = 8'h2F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic [IDX_W-1:0]  host_index,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_oe_hi,
    output logic              host_oe_lo,
    output logic              gps_o,
    output logic              gps_oe
);

    localparam int PORT_LSB = DATA_W - PORT_W;

    logic              port_hit;
    logic              ctrl_hit;
    logic              strobe_act;
    logic [CTRL_W-1:0] ctl;
    logic [PORT_W-1:0] shadow;
    gps_mode_e         mode;

    gps_access_decode #(
        .IDX_W    (IDX_W),
        .PORT_IDX (PORT_IDX),
        .CTRL_IDX (CTRL_IDX)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_index (host_index),
        .host_wr_n  (host_wr_n),
        .host_rd_n  (host_rd_n),
        .mode       (mode),
        .port_hit   (port_hit),
        .ctrl_hit   (ctrl_hit),
        .strobe_act (strobe_act)
    );

    gps_regfile #(
        .DATA_W (DATA_W),
        .PORT_W (PORT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr_n (host_wr_n),
        .host_rd_n (host_rd_n),
        .host_din  (host_din),
        .port_hit  (port_hit),
        .ctrl_hit  (ctrl_hit),
        .ctl       (ctl),
        .shadow    (shadow),
        .mode      (mode)
    );

    gps_pin_drv u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_act (strobe_act),
        .push_pull  (ctl[DRV_BIT]),
        .pin_o      (gps_o),
        .pin_oe     (gps_oe)
    );

    // Lane drive enables: read-strobe mode leaves the port lane to the buffer.
    always_comb begin
        host_oe_lo = ctrl_hit && !host_rd_n;
        host_oe_hi = port_hit && !host_rd_n && (mode != MODE_RDSTB);
    end

    // Read data assembly per lane; undriven lanes read as zero.
    always_comb begin
        host_dout = '0;
        if (host_oe_lo) host_dout[CTRL_W-1:0] = ctl;
        if (host_oe_hi) host_dout[PORT_LSB +: PORT_W] = shadow;
    end

    // R4: the port lane is never driven by the block in read-strobe mode.
    p_no_drive_rdstb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[MODE_LSB +: 2] == 2'b01) |-> !host_oe_hi)
        else $error("port lane driven in read-strobe mode");

    // R6: idle modes never pull the pin low.
    p_idle_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[MODE_LSB +: 2] == 2'b00 || ctl[MODE_LSB +: 2] == 2'b11)
        |-> (gps_o || !gps_oe))
        else $error("pin pulled low in idle mode");

    // R9: nothing is driven without a data-port select.
    p_unsel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (!host_oe_hi && !host_oe_lo && (gps_o || !gps_oe)))
        else $error("activity without host select");

endmodule

// File: tb/tb_gps_strobe_port.sv
// Bench: behavioural reference model compared on every clock, plus
// directed value checks at the points the requirements name.
module tb_gps_strobe_port;

    localparam int DW = 16;
    localparam logic [7:0] PIDX = 8'h0A;
    localparam logic [7:0] CIDX = 8'h2F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic [7:0]  host_index = 8'h00;
    logic        host_wr_n = 1'b1;
    logic        host_rd_n = 1'b1;
    logic [15:0] host_din = 16'h0000;
    logic [15:0] host_dout;
    logic        host_oe_hi, host_oe_lo, gps_o, gps_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit compare_on = 1'b0;

    // Model state
    logic [7:0]  m_ctl, m_shadow;
    bit          m_wr_busy, m_rd_busy;
    bit          m_wr_sel, m_rd_sel;
    logic [7:0]  m_wr_idx, m_rd_idx;
    logic [15:0] m_wr_dat, m_rd_dat;

    always #10 clk = ~clk;

    gps_strobe_port #(
        .DATA_W(DW), .PORT_W(8), .IDX_W(8), .PORT_IDX(PIDX), .CTRL_IDX(CIDX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_index(host_index),
        .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_din(host_din),
        .host_dout(host_dout), .host_oe_hi(host_oe_hi), .host_oe_lo(host_oe_lo),
        .gps_o(gps_o), .gps_oe(gps_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: remember the latest low cycle, act when the pulse ends.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 8'h00; m_shadow = 8'h00;
            m_wr_busy = 0; m_rd_busy = 0;
        end else begin
            if (m_wr_busy && host_wr_n) begin
                if (m_wr_sel && m_wr_idx == CIDX) m_ctl = m_wr_dat[7:0];
                if (m_wr_sel && m_wr_idx == PIDX) m_shadow = m_wr_dat[15:8];
            end
            if (m_rd_busy && host_rd_n && m_rd_sel && m_rd_idx == PIDX
                && m_ctl[4:3] == 2'b01)
                m_shadow = m_rd_dat[15:8];
            m_wr_busy = !host_wr_n;
            m_rd_busy = !host_rd_n;
            if (!host_wr_n) begin m_wr_sel = host_sel; m_wr_idx = host_index; m_wr_dat = host_din; end
            if (!host_rd_n) begin m_rd_sel = host_sel; m_rd_idx = host_index; m_rd_dat = host_din; end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (compare_on) begin
            bit strobe, pp, oe_hi, oe_lo;
            logic [15:0] dexp;
            string stag;
            pp    = m_ctl[2];
            strobe = host_sel && host_index == PIDX &&
                     ((m_ctl[4:3] == 2'b10 && !host_wr_n) ||
                      (m_ctl[4:3] == 2'b01 && !host_rd_n));
            oe_lo = host_sel && !host_rd_n && host_index == CIDX;
            oe_hi = host_sel && !host_rd_n && host_index == PIDX && m_ctl[4:3] != 2'b01;
            dexp  = {oe_hi ? m_shadow : 8'h00, oe_lo ? m_ctl : 8'h00};
            stag  = !host_sel ? "R9" : (host_index != PIDX) ? "R7" :
                    (m_ctl[4:3] == 2'b10) ? "R2" : (m_ctl[4:3] == 2'b01) ? "R4" : "R6";
            check(stag, "pin level(R8)", {15'd0, gps_o}, {15'd0, pp ? !strobe : 1'b0});
            check(stag, "pin enable(R8)", {15'd0, gps_oe}, {15'd0, pp ? 1'b1 : strobe});
            check(m_ctl[4:3] == 2'b01 ? "R4" : "R3", "oe_hi", {15'd0, host_oe_hi}, {15'd0, oe_hi});
            check("R7", "oe_lo", {15'd0, host_oe_lo}, {15'd0, oe_lo});
            check("R3", "dout", host_dout, dexp);
        end
    end

    task automatic host_write(input bit sel, input logic [7:0] idx,
                              input logic [15:0] dat, input int len);
        @(posedge clk); #2;
        host_sel = sel; host_index = idx; host_din = dat; host_wr_n = 1'b0;
        repeat (len) @(posedge clk);
        #2; host_wr_n = 1'b1;
        @(posedge clk); #2; host_sel = 1'b0; host_din = 16'h0000;
        @(posedge clk);
    endtask

    // Read; returns dout seen in the last low cycle.
    task automatic host_read(input bit sel, input logic [7:0] idx,
                             input logic [7:0] ext, input int len,
                             output logic [15:0] got);
        @(posedge clk); #2;
        host_sel = sel; host_index = idx; host_din = {ext, 8'h00}; host_rd_n = 1'b0;
        repeat (len) @(posedge clk);
        #6; got = host_dout;
        host_rd_n = 1'b1;
        @(posedge clk); #2; host_sel = 1'b0; host_din = 16'h0000;
        @(posedge clk);
    endtask

    initial begin : watchdog
        #4ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog (R1..) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] r;
        repeat (3) @(posedge clk);
        #2; rst_n = 1'b1; compare_on = 1'b1;
        // R1 reset state
        host_read(1, CIDX, 8'h00, 1, r);
        check("R1", "ctl after reset", r, 16'h0000);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R1", "shadow after reset", r, 16'h0000);
        check("R1", "pin not low", {15'd0, gps_oe && !gps_o}, 16'h0000);
        // write-strobe, push-pull: ctl = 0x14
        host_write(1, CIDX, 16'h0014, 1);
        host_read(1, CIDX, 8'h00, 2, r);
        check("R7", "ctl readback", r, 16'h0014);
        host_write(1, PIDX, 16'hA5FF, 3);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R3", "shadow after write", r, 16'hA500);
        // write-strobe, open drain
        host_write(1, CIDX, 16'h0010, 1);
        host_write(1, PIDX, 16'h3C00, 1);
        host_read(1, PIDX, 8'h00, 2, r);
        check("R3", "shadow open-drain write", r, 16'h3C00);
        // read-strobe, push-pull: ctl = 0x0C
        host_write(1, CIDX, 16'h000C, 1);
        host_read(1, PIDX, 8'h5A, 3, r);
        check("R4", "no drive of port lane", {15'd0, host_oe_hi}, 16'h0000);
        host_write(1, PIDX, 16'h7700, 2);
        // R5: shadow captured 0x5A then overwritten to 0x77; verify via mode 00
        host_write(1, CIDX, 16'h0004, 1);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R6", "plain register after rd-mode write", r, 16'h7700);
        host_write(1, CIDX, 16'h000C, 1);
        host_read(1, PIDX, 8'hC3, 2, r);
        host_write(1, CIDX, 16'h0000, 1);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R5", "captured buffer byte", r, 16'hC300);
        // mode 11, open drain
        host_write(1, CIDX, 16'h0018, 1);
        host_write(1, PIDX, 16'h9900, 2);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R6", "mode 11 plain register", r, 16'h9900);
        // R7 neighbour index in write-strobe mode
        host_write(1, CIDX, 16'h0014, 1);
        host_write(1, 8'h0B, 16'h1100, 2);
        host_read(1, 8'h0B, 8'h00, 1, r);
        check("R7", "other index no drive", r, 16'h0000);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R7", "shadow untouched by other index", r, 16'h9900);
        // R9 unselected
        host_write(0, PIDX, 16'hEE00, 2);
        host_write(0, CIDX, 16'h0008, 1);
        host_read(0, PIDX, 8'h00, 1, r);
        check("R9", "unselected read no drive", r, 16'h0000);
        host_read(1, PIDX, 8'h00, 1, r);
        check("R9", "shadow after unselected write", r, 16'h9900);
        host_read(1, CIDX, 8'h00, 1, r);
        check("R9", "ctl after unselected write", r, 16'h0014);
        // R1 reset again
        @(posedge clk); #2; rst_n = 1'b0; compare_on = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1; compare_on = 1'b1;
        host_read(1, PIDX, 8'h00, 1, r);
        check("R1", "shadow after second reset", r, 16'h0000);
        repeat (3) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule